// File: doc/BRIEF.md
# Asynchronous SRAM Bus Timing Monitor

This block watches an asynchronous static-RAM interface (chip select, output enable and write enable, all active low, plus the address, the data bus and a flag telling whether the host is driving the data bus). It samples all of them on a fast clock and flags breaches of the write and read timing rules. Every limit is a parameter in sample-clock periods, so a check is accurate to one sample. The defaults assume a 10 ns sample clock and a 45 ns memory grade.

A write is the span in which chip select and write enable are both low. It opens at whichever strobe falls last and closes at whichever strobe rises first. The write checks measure their setup times back from the close of this span, not from one strobe edge. For each rule the monitor keeps a sticky flag. It also keeps a 16-bit saturating total of the violations. A controller testbench can poll these outputs, and they can also be built into silicon next to a memory controller. A synchronous clear input resets both the flags and the total.

Top module: `sram_timing_mon`

## Requirements
- R1: A write span shorter than T_WP samples (default 4) sets flag bit 0 in the cycle after it closes. The span opens at the later of the two strobe falls and closes at the earlier of the two strobe rises.
- R2: When a write span closes, chip select must have been low for at least T_CW samples (default 5). Otherwise flag bit 1 is set.
- R3: When a write span closes, the address must have been steady for at least T_AW samples (default 5). Otherwise flag bit 2 is set.
- R4: When a write span closes, the data bus must have been steady for at least T_DW samples (default 3). Otherwise flag bit 3 is set.
- R5: An address change seen while the write span stays open sets flag bit 4.
- R6: An address change in the same sample that opens a write span breaks the zero setup rule and sets flag bit 5.
- R7: An address change less than T_WC samples (default 5) after the previous one, with a write span inside that interval, sets flag bit 6.
- R8: An address change less than T_RC samples (default 5) after the previous one, with chip select low and no write in that interval, sets flag bit 7.
- R9: A sample in which the host drives the bus while chip select and output enable are low and write enable is high sets flag bit 8. A write entered with output enable low, where the host drives only while write enable is low, sets no flag.
- R10: Each flag bit stays set until a sample in which the clear input is high. In that sample the flags take only the violations of that same sample.
- R11: Each sample adds its number of violated rules to err_count. The count holds at 65535. The clear input resets the count to the violations of its own sample.
- R12: After reset, err_flags and err_count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of flags and count |
| cs_n | input | 1 | Observed chip select, active low |
| oe_n | input | 1 | Observed output enable, active low |
| we_n | input | 1 | Observed write enable, active low |
| addr | input | ADDR_W | Observed address |
| dq | input | DATA_W | Observed data bus |
| host_drv | input | 1 | High when the host drives the data bus |
| err_flags | output | 9 | Sticky per-rule violation flags |
| err_count | output | 16 | Saturating violation total |

## Verification
A vector table runs write cycles that differ in address lead, chip-select lead, window width and data lead. Each row places its single close sample against a different set of the four window limits, and checks that each limit trips on its own or together with others. Directed cases separate the order of the strobes, an address change in the opening sample from one inside the window, back-to-back writes from fast reads, and a legal write with output enable low from true bus contention. A long run of contention drives the count into saturation, and clears are checked after it.

// File: rtl/sram_timing_mon.sv
module sram_timing_mon #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int T_WP   = 4,
  parameter int T_CW   = 5,
  parameter int T_AW   = 5,
  parameter int T_DW   = 3,
  parameter int T_WC   = 5,
  parameter int T_RC   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq,
  input  logic              host_drv,
  output logic [8:0]        err_flags,
  output logic [15:0]       err_count
);
  localparam int NR = 9;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] L_WP = CNT_W'(T_WP);
  localparam logic [CNT_W-1:0] L_CW = CNT_W'(T_CW);
  localparam logic [CNT_W-1:0] L_AW = CNT_W'(T_AW);
  localparam logic [CNT_W-1:0] L_DW = CNT_W'(T_DW);
  localparam logic [CNT_W-1:0] L_WC = CNT_W'(T_WC);
  localparam logic [CNT_W-1:0] L_RC = CNT_W'(T_RC);

  logic              primed, win_q, wr_seen, sel_seen;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dq_q;
  logic [CNT_W-1:0]  w_cnt, cs_cnt, a_cnt, d_cnt;
  logic [NR-1:0]     viol;
  logic [16:0]       cnt_sum;
  logic [15:0]       cnt_base;

  wire win     = !cs_n && !we_n;
  wire w_open  = win && !win_q;
  wire w_close = !win && win_q;
  wire a_chg   = primed && (addr != addr_q);
  wire d_chg   = primed && (dq != dq_q);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  assign viol[0] = w_close && (w_cnt  < L_WP);
  assign viol[1] = w_close && (cs_cnt < L_CW);
  assign viol[2] = w_close && (a_cnt  < L_AW);
  assign viol[3] = w_close && (d_cnt  < L_DW);
  assign viol[4] = win && win_q && a_chg;
  assign viol[5] = w_open && a_chg;
  assign viol[6] = a_chg && wr_seen && (a_cnt < L_WC);
  assign viol[7] = a_chg && !wr_seen && sel_seen && (a_cnt < L_RC);
  assign viol[8] = host_drv && !cs_n && !oe_n && we_n;

  assign cnt_base = clr ? 16'd0 : err_count;
  assign cnt_sum  = {1'b0, cnt_base} + 17'($countones(viol));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      win_q     <= 1'b0;
      wr_seen   <= 1'b0;
      sel_seen  <= 1'b0;
      addr_q    <= '0;
      dq_q      <= '0;
      w_cnt     <= '0;
      cs_cnt    <= '0;
      a_cnt     <= '0;
      d_cnt     <= '0;
      err_flags <= '0;
      err_count <= '0;
    end else begin
      primed   <= 1'b1;
      win_q    <= win;
      addr_q   <= addr;
      dq_q     <= dq;
      w_cnt    <= win  ? sat_inc(w_cnt)  : '0;
      cs_cnt   <= !cs_n ? sat_inc(cs_cnt) : '0;
      a_cnt    <= a_chg ? CNT_W'(1) : sat_inc(a_cnt);
      d_cnt    <= d_chg ? CNT_W'(1) : sat_inc(d_cnt);
      wr_seen  <= a_chg ? win    : (wr_seen  | win);
      sel_seen <= a_chg ? !cs_n  : (sel_seen | !cs_n);
      err_flags <= (clr ? '0 : err_flags) | viol;
      err_count <= cnt_sum[16] ? 16'hFFFF : cnt_sum[15:0];
    end
  end
endmodule

module sram_timing_mon_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        cs_n,
  input logic        oe_n,
  input logic        we_n,
  input logic        host_drv,
  input logic [8:0]  err_flags,
  input logic [15:0] err_count
);
  // R10
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R11
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (err_count >= $past(err_count)));

  // R11
  clear_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_count == 16'($countones(err_flags))));

  // R9
  contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_drv && !cs_n && !oe_n && we_n) |=> err_flags[8]);
endmodule

bind sram_timing_mon sram_timing_mon_chk chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
  .host_drv(host_drv), .err_flags(err_flags), .err_count(err_count)
);

// File: tb/sram_timing_mon_tb_top.sv
module sram_timing_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, host_drv = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  dq = '0;
  logic [8:0]  err_flags;
  logic [15:0] err_count;
  int tot = 0, bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  sram_timing_mon dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq(dq), .host_drv(host_drv),
    .err_flags(err_flags), .err_count(err_count)
  );

  // a_pre, cs_pre, wp, d_len, expected flag mask
  localparam int VEC [0:6][0:4] = '{
    '{1, 1, 4, 3, 'h000},
    '{1, 1, 3, 3, 'h003},
    '{1, 0, 5, 2, 'h008},
    '{1, 0, 4, 4, 'h002},
    '{2, 3, 4, 1, 'h008},
    '{1, 0, 2, 1, 'h00F},
    '{3, 2, 6, 6, 'h000}
  };

  task automatic put(input logic c, input logic o, input logic w,
                     input logic [18:0] a, input logic [7:0] d, input logic h);
    @(negedge clk);
    cs_n = c; oe_n = o; we_n = w; addr = a; dq = d; host_drv = h;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b1, 1'b1, 1'b1, addr, dq, 1'b0);
  endtask

  task automatic chk(input logic [8:0] ef, input logic [15:0] ec, input string tag);
    @(negedge clk);
    tot++;
    if (err_flags !== ef || err_count !== ec) begin
      bad++;
      $display("FAIL %s: flags=%h count=%0d expected flags=%h count=%0d",
               tag, err_flags, err_count, ef, ec);
    end
  endtask

  task automatic clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tot++; bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", tot, bad);
      $finish;
    end
  end

  initial begin
    logic [18:0] a;
    logic [7:0]  d;
    repeat (3) @(negedge clk);
    chk(9'h0, 16'd0, "R12 reset state");
    rst_n = 1'b1;
    idle(8);
    chk(9'h0, 16'd0, "R12 idle after reset");

    // table of write cycles: R1 R2 R3 R4 R11
    a = 19'h100; d = 8'h3C;
    for (int v = 0; v < 7; v++) begin
      int t;
      logic [7:0] dn;
      t = VEC[v][0] + VEC[v][1] + VEC[v][2];
      a = a + 19'd1; dn = d ^ 8'hA5;
      for (int k = 0; k < t; k++) begin
        logic c, w;
        c = (k >= VEC[v][0]) ? 1'b0 : 1'b1;
        w = (k >= VEC[v][0] + VEC[v][1]) ? 1'b0 : 1'b1;
        put(c, 1'b1, w, a, (k >= t - VEC[v][3]) ? dn : d, 1'b0);
      end
      d = dn;
      idle(8);
      chk(9'(VEC[v][4]), 16'($countones(9'(VEC[v][4]))),
          $sformatf("R1 R2 R3 R4 R11 vector %0d", v));
      clear();
    end

    // R6: address changes in the sample that opens the window
    a = a + 1;
    for (int k = 0; k < 5; k++) put(1'b0, 1'b1, 1'b0, a, d, 1'b0);
    idle(8);
    chk(9'h020, 16'd1, "R6 address change at window open");
    clear();

    // R5 R3: address changes inside an open window
    for (int k = 0; k < 6; k++) put(1'b0, 1'b1, 1'b0, (k >= 3) ? a + 19'd1 : a, d, 1'b0);
    a = a + 1;
    idle(8);
    chk(9'h014, 16'd2, "R5 address change during window");
    clear();

    // R7: short write cycle followed by a quick address change
    a = a + 1;
    put(1'b1, 1'b1, 1'b1, a, d, 1'b0);
    put(1'b0, 1'b1, 1'b0, a, d, 1'b0);
    put(1'b0, 1'b1, 1'b0, a, d, 1'b0);
    put(1'b1, 1'b1, 1'b1, a, d, 1'b0);
    a = a + 1;
    put(1'b1, 1'b1, 1'b1, a, d, 1'b0);
    idle(8);
    chk(9'h047, 16'd4, "R7 write cycle too short");
    clear();

    // R8: fast read cycle then a legal one
    a = a + 1;
    for (int k = 0; k < 3; k++) put(1'b0, 1'b0, 1'b1, a, d, 1'b0);
    a = a + 1;
    for (int k = 0; k < 6; k++) put(1'b0, 1'b0, 1'b1, a, d, 1'b0);
    a = a + 1;
    put(1'b1, 1'b1, 1'b1, a, d, 1'b0);
    idle(8);
    chk(9'h080, 16'd1, "R8 read cycle too short");
    clear();

    // R8: read cycle exactly at the limit is legal
    a = a + 1;
    for (int k = 0; k < 5; k++) put(1'b0, 1'b0, 1'b1, a, d, 1'b0);
    a = a + 1;
    put(1'b0, 1'b0, 1'b1, a, d, 1'b0);
    idle(8);
    chk(9'h000, 16'd0, "R8 read cycle at limit");
    clear();

    // R1 R2: write closed by chip select with enable still low, CS low 4
    a = a + 1;
    put(1'b1, 1'b1, 1'b1, a, d, 1'b0);
    put(1'b1, 1'b1, 1'b0, a, d, 1'b0);
    for (int k = 0; k < 4; k++) put(1'b0, 1'b1, 1'b0, a, d, 1'b0);
    put(1'b1, 1'b1, 1'b0, a, d, 1'b0);
    idle(8);
    chk(9'h002, 16'd1, "R1 R2 chip-select controlled write");
    clear();

    // R9: write entered with output enable low, host drives only during write
    a = a + 1;
    put(1'b0, 1'b0, 1'b1, a, d, 1'b0);
    for (int k = 0; k < 5; k++) put(1'b0, 1'b0, 1'b0, a, d, 1'b1);
    idle(8);
    chk(9'h000, 16'd0, "R9 write with output enable low");
    clear();

    // R9 R10: contention, then flag stays set
    put(1'b0, 1'b0, 1'b1, a, d, 1'b1);
    idle(1);
    chk(9'h100, 16'd1, "R9 bus contention");
    idle(4);
    chk(9'h100, 16'd1, "R10 flag sticky");
    clear();
    chk(9'h000, 16'd0, "R10 clear");

    // R11: saturation
    for (int k = 0; k < 65540; k++) put(1'b0, 1'b0, 1'b1, a, d, 1'b1);
    idle(1);
    chk(9'h100, 16'hFFFF, "R11 count saturates");
    clear();
    chk(9'h000, 16'd0, "R10 R11 clear after saturation");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule